// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. It holds a set of 8-pin ports, up to seven. Each port has its own 48-byte register window on a simple 32-bit register bus. For every pin, software picks an output drive style, controls a pull-up, writes an output value and reads back the synchronized pad level. Each pin latches one selected edge as an interrupt event.

Every port drives one interrupt line, formed from its latched events and an enable mask. Events are cleared by writing ones. A test force register can inject events. A global control word reports how the block is built, picks the depth of the input synchronizer and gates event capture. Pad signals leave the block as output value, output enable and pull-up enable per pin. The pad itself sits outside.

Top module: `pio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input: pad_oe and pad_out are all 0 and pad_pu is all 1. Every irq line is 0, and control bits [1:0] read 0.
- R2: The control word sits at byte address 0x000. Bits [15:9] read the port count, bits [8:2] read the VERSION parameter, bits [1:0] are read/write, and all other bits read 0. The control word changes only when it is written.
- R3: The mode register (offset 0x0C) holds 2 bits per pin, with pin n at bits [2n+1:2n]. The codes are 00 input, 01 push-pull, 10 open-drain and 11 open-source. The output enable is always on for push-pull. For open-drain it is on only while the pin's data bit is 0, and for open-source only while it is 1. pad_out always equals the output data register (offset 0x08).
- R4: In the pull register (offset 0x10), a 0 bit turns the pull-up on and a 1 bit turns it off. pad_pu is 1 only for a pin in input mode whose pull bit is 0.
- R5: The input register (offset 0x04) returns the pad levels in any pin mode. With control bit 1 set, a pad change shows after the 2nd rising clock edge. With bit 1 clear, it shows after the 1st.
- R6: In the edge register (offset 0x20), 0 selects the falling edge and 1 selects the rising edge. The selected edge sets the pin's bit in the event register (offset 0x14). With two-stage sync, the bit is set after the 3rd clock edge from the pad change. The other edge sets nothing.
- R7: Writing a 1 to an event bit clears it. Writing a 0 leaves it alone. A new event in the same cycle wins over the clear.
- R8: A port's irq is the OR of event AND enable (offset 0x18) over its pins. Events latch even while their enable is 0.
- R9: While a bit of the force register (offset 0x1C) is 1 and the block is enabled, the matching event bit is set one clock later. Writing 0 stops forcing.
- R10: While control bit 0 is 0, neither pad edges nor force bits set events.
- R11: Port p occupies byte addresses 0x30*p to 0x30*p+0x2F. Each port acts only on its own pins and irq line. Offset 0x00 of a port other than port 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad output values |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |
| pad_pu | output | 8*NUM_PORTS | Pad pull-up enables |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
Register writes take effect at the rising edge inside the write access. Read data is combinational, so a read is sampled 1 ns after the address is applied, away from any edge. For pad stimulus, the bench changes the pin on a falling edge and counts rising edges. Readback is due after 2 edges (1 in single-stage mode), and the event and irq after 3. The bench also samples one edge early to confirm the old value still holds. Force takes effect one edge after the force write.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int WIN_BYTES     = 48;

  typedef enum logic [5:0] {
    OFF_CTRL = 6'h00,
    OFF_IN   = 6'h04,
    OFF_DOUT = 6'h08,
    OFF_MODE = 6'h0C,
    OFF_PULL = 6'h10,
    OFF_EVT  = 6'h14,
    OFF_IEN  = 6'h18,
    OFF_FRC  = 6'h1C,
    OFF_EDGE = 6'h20
  } win_off_e;

  typedef enum logic [1:0] {
    PM_IN = 2'b00,
    PM_PP = 2'b01,
    PM_OD = 2'b10,
    PM_OS = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         two_stage,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  assign level = two_stage ? s2_q : s1_q;
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= level;
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int PORT_IDX = 0,
  parameter int ADDR_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              sync_two,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [31:0]       rdata,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe,
  output logic [7:0]        pad_pu,
  output logic              irq
);
  localparam logic [ADDR_W:0] BASE = (ADDR_W+1)'(PORT_IDX * WIN_BYTES);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(WIN_BYTES);

  logic [ADDR_W:0] rel;
  logic            hit;
  logic [5:0]      off;
  assign rel = {1'b0, bus_addr} - BASE;
  assign hit = bus_sel && ({1'b0, bus_addr} >= BASE) && (rel < SPAN);
  assign off = rel[5:0] & 6'h3C;

  logic wr_dout, wr_mode, wr_pull, wr_ev, wr_ien, wr_frc, wr_edge;
  assign wr_dout = hit && bus_wr && (off == OFF_DOUT);
  assign wr_mode = hit && bus_wr && (off == OFF_MODE);
  assign wr_pull = hit && bus_wr && (off == OFF_PULL);
  assign wr_ev   = hit && bus_wr && (off == OFF_EVT);
  assign wr_ien  = hit && bus_wr && (off == OFF_IEN);
  assign wr_frc  = hit && bus_wr && (off == OFF_FRC);
  assign wr_edge = hit && bus_wr && (off == OFF_EDGE);

  logic [7:0]  dout_q, pull_q, ev_q, ien_q, frc_q, edge_q;
  logic [15:0] mode_q;
  logic [7:0]  dout_d, pull_d, ev_d, ien_d, frc_d, edge_d;
  logic [15:0] mode_d;

  logic [7:0] lvl, rise, fall, ev_set, ev_clr;

  pio_sync #(.W(PINS_PER_PORT)) u_sync (
    .clk(clk), .rst_n(rst_n), .two_stage(sync_two),
    .din(pad_in), .level(lvl), .rise(rise), .fall(fall)
  );

  assign ev_set = blk_en ? ((edge_q & rise) | (~edge_q & fall) | frc_q) : 8'h00;
  assign ev_clr = wr_ev ? bus_wdata[7:0] : 8'h00;

  always_comb begin
    dout_d = wr_dout ? bus_wdata[7:0] : dout_q;
    mode_d = wr_mode ? bus_wdata      : mode_q;
    pull_d = wr_pull ? bus_wdata[7:0] : pull_q;
    ien_d  = wr_ien  ? bus_wdata[7:0] : ien_q;
    frc_d  = wr_frc  ? bus_wdata[7:0] : frc_q;
    edge_d = wr_edge ? bus_wdata[7:0] : edge_q;
    ev_d   = (ev_q & ~ev_clr) | ev_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      mode_q <= '0;
      pull_q <= '0;
      ev_q   <= '0;
      ien_q  <= '0;
      frc_q  <= '0;
      edge_q <= '0;
    end else begin
      dout_q <= dout_d;
      mode_q <= mode_d;
      pull_q <= pull_d;
      ev_q   <= ev_d;
      ien_q  <= ien_d;
      frc_q  <= frc_d;
      edge_q <= edge_d;
    end
  end

  for (genvar i = 0; i < PINS_PER_PORT; i++) begin : g_pin
    pin_mode_e m;
    assign m         = pin_mode_e'(mode_q[2*i+1:2*i]);
    assign pad_oe[i] = (m == PM_PP) | ((m == PM_OD) & ~dout_q[i]) | ((m == PM_OS) & dout_q[i]);
    assign pad_pu[i] = (m == PM_IN) & ~pull_q[i];
  end
  assign pad_out = dout_q;
  assign irq     = |(ev_q & ien_q);

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (off)
        OFF_IN:   rdata[7:0]  = lvl;
        OFF_DOUT: rdata[7:0]  = dout_q;
        OFF_MODE: rdata[15:0] = mode_q;
        OFF_PULL: rdata[7:0]  = pull_q;
        OFF_EVT:  rdata[7:0]  = ev_q;
        OFF_IEN:  rdata[7:0]  = ien_q;
        OFF_FRC:  rdata[7:0]  = frc_q;
        OFF_EDGE: rdata[7:0]  = edge_q;
        default:  rdata       = '0;
      endcase
    end
  end

  // R7
  ev_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && bus_wdata[7:0] == 8'hFF && !blk_en) |=> (ev_q == 8'h00));
  // R10
  ev_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && !wr_ev) |=> $stable(ev_q));
  // R9
  force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && frc_q != 8'h00) |=> ((ev_q & $past(frc_q)) == $past(frc_q)));
endmodule

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl
  import pio_pkg::*;
#(
  parameter int          NUM_PORTS = 2,
  parameter logic [6:0]  VERSION   = 7'h03,
  parameter int          ADDR_W    = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [8*NUM_PORTS-1:0]       pad_in,
  output logic [8*NUM_PORTS-1:0]       pad_out,
  output logic [8*NUM_PORTS-1:0]       pad_oe,
  output logic [8*NUM_PORTS-1:0]       pad_pu,
  output logic [NUM_PORTS-1:0]         irq
);
  localparam logic [6:0] PORT_CNT = 7'(NUM_PORTS);

  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic wdata_unused;
  assign wdata_unused = ^bus_wdata[31:16];

  logic       ctrl_hit, ctrl_wr;
  logic [1:0] ctrl_q, ctrl_d;
  assign ctrl_hit = bus_sel && (bus_addr[ADDR_W-1:2] == '0);
  assign ctrl_wr  = ctrl_hit && bus_wr;

  always_comb ctrl_d = ctrl_wr ? bus_wdata[1:0] : ctrl_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  logic [31:0] port_rd [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio_port #(.PORT_IDX(p), .ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst_n(rst_n_s),
      .blk_en(ctrl_q[0]), .sync_two(ctrl_q[1]),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata[15:0]), .rdata(port_rd[p]),
      .pad_in(pad_in[8*p+7:8*p]), .pad_out(pad_out[8*p+7:8*p]),
      .pad_oe(pad_oe[8*p+7:8*p]), .pad_pu(pad_pu[8*p+7:8*p]),
      .irq(irq[p])
    );
  end

  always_comb begin
    bus_rdata = ctrl_hit ? {16'h0, PORT_CNT, VERSION, ctrl_q} : 32'h0;
    for (int p = 0; p < NUM_PORTS; p++) bus_rdata = bus_rdata | port_rd[p];
  end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctrl_wr |=> $stable(ctrl_q));
endmodule

// File: tb/pio_bank_ctrl_test.sv
`timescale 1ns/1ps
module pio_bank_ctrl_test;
  localparam int NP = 2;
  localparam int NPIN = 8*NP;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_wr;
  logic [8:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NPIN-1:0] pad_in, pad_out, pad_oe, pad_pu;
  logic [NP-1:0]   irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio_bank_ctrl #(.NUM_PORTS(NP), .VERSION(7'h03), .ADDR_W(9)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pad(input int k, input logic v);
    @(negedge clk);
    pad_in[k] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 pad_pu", 32'(pad_pu), 32'hFFFF);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(9'h000, d);
    chk("R2 control id", d, (32'(NP) << 9) | (32'h3 << 2));
  endtask

  task automatic t_drive;
    wr(9'h00C, 32'h39);
    wr(9'h008, 32'h06);
    #1;
    chk("R3 oe data=06", 32'(pad_oe[7:0]), 32'h05);
    chk("R3 pad_out", 32'(pad_out[7:0]), 32'h06);
    wr(9'h008, 32'h00);
    #1;
    chk("R3 oe data=00", 32'(pad_oe[7:0]), 32'h03);
  endtask

  task automatic t_pull;
    wr(9'h010, 32'h08);
    #1;
    chk("R4 pull port0", 32'(pad_pu[7:0]), 32'hF0);
    chk("R4 pull port1", 32'(pad_pu[15:8]), 32'hFF);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(9'h000, 32'h3);
    set_pad(0, 1'b1);
    edges(1);
    rd(9'h004, d);
    chk("R5 two-stage edge1", d, 32'h00);
    edges(1);
    rd(9'h004, d);
    chk("R5 two-stage pp pin", d, 32'h01);
    wr(9'h000, 32'h1);
    set_pad(1, 1'b1);
    edges(1);
    rd(9'h004, d);
    chk("R5 one-stage", d, 32'h03);
    wr(9'h000, 32'h3);
    edges(3);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(9'h020, 32'h10);
    wr(9'h018, 32'hFF);
    rd(9'h014, d);
    chk("R6 no event before", d, 32'h00);
    set_pad(4, 1'b1);
    edges(2);
    rd(9'h014, d);
    chk("R6 event after 2 edges", d, 32'h00);
    chk("R8 irq not yet", 32'(irq), 32'h0);
    edges(1);
    rd(9'h014, d);
    chk("R6 rising event", d, 32'h10);
    chk("R8 irq port0", 32'(irq), 32'h1);
    set_pad(5, 1'b1);
    edges(4);
    rd(9'h014, d);
    chk("R6 opposite edge ignored", d, 32'h10);
    set_pad(5, 1'b0);
    edges(3);
    rd(9'h014, d);
    chk("R6 falling event", d, 32'h30);
  endtask

  task automatic t_w1c_mask;
    logic [31:0] d;
    wr(9'h014, 32'h10);
    rd(9'h014, d);
    chk("R7 w1c clears one bit", d, 32'h20);
    wr(9'h018, 32'h00);
    #1;
    chk("R8 irq masked", 32'(irq), 32'h0);
    rd(9'h014, d);
    chk("R8 event held while masked", d, 32'h20);
    wr(9'h014, 32'h20);
    rd(9'h014, d);
    chk("R7 w1c clears last bit", d, 32'h00);
  endtask

  task automatic t_force;
    logic [31:0] d;
    wr(9'h01C, 32'h01);
    edges(1);
    rd(9'h014, d);
    chk("R9 forced event", d, 32'h01);
    wr(9'h01C, 32'h00);
    wr(9'h014, 32'h01);
    edges(2);
    rd(9'h014, d);
    chk("R9 force off", d, 32'h00);
  endtask

  task automatic t_ports;
    logic [31:0] d;
    wr(9'h038, 32'hA5);
    #1;
    chk("R11 port1 out", 32'(pad_out[15:8]), 32'hA5);
    chk("R11 port0 out untouched", 32'(pad_out[7:0]), 32'h00);
    rd(9'h030, d);
    chk("R11 port1 offset0", d, 32'h0);
    wr(9'h048, 32'h01);
    wr(9'h04C, 32'h01);
    edges(1);
    chk("R11 irq port1 only", 32'(irq), 32'h2);
    wr(9'h04C, 32'h00);
    wr(9'h044, 32'h01);
    edges(1);
    chk("R11 irq port1 cleared", 32'(irq), 32'h0);
  endtask

  task automatic t_off;
    logic [31:0] d;
    wr(9'h000, 32'h2);
    rd(9'h000, d);
    chk("R2 control bits", d & 32'h3, 32'h2);
    wr(9'h01C, 32'hFF);
    set_pad(4, 1'b0);
    set_pad(6, 1'b1);
    edges(5);
    rd(9'h014, d);
    chk("R10 no events when off", d, 32'h00);
    wr(9'h01C, 32'h00);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);
    t_reset;
    t_drive;
    t_pull;
    t_readback;
    t_edges;
    t_w1c_mask;
    t_force;
    t_ports;
    t_off;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule